// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of a 12-bit successive-approximation converter. An asynchronous convert-start edge is brought into the conversion clock domain. The track/hold is then switched to hold, and the block searches the code space one bit at a time. For each trial it presents a code to an external DAC and reads back a single comparator decision. When the search ends, the block stores the code, releases the busy status and returns the track/hold to tracking. A host reads the stored code by pulling chip-select and read low together. Outside that window, and throughout a conversion, the result bus is left undriven.

A power-mode input puts the block to sleep when it is low while read is inactive. Sleep lasts until the mode input returns high. One wake clock follows, during which a start is not accepted. The first conversion after a sleep is a dummy conversion. A status flag marks its result as not valid, and the next conversion clears the flag.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy_n_o is 1, hold_o is 0 (tracking), dac_code_o is 0, data_oe_o is 0 with cs_n_i high, pwr_down_o is 0, result_invalid_o is 0, and the stored result is 0.
- R2: The first rising clock edge that samples conv_start_i high is edge 1. If the block is idle and awake, busy_n_o falls and hold_o rises right after edge 3. Both return (busy_n_o high, hold_o low) right after edge 27, so busy_n_o stays low for exactly 24 clock periods.
- R3: The search starts with only bit 11 set in dac_code_o. Each trial code is held for two clocks. On the second of those clocks the trial bit is kept if cmp_i is 1 (input at or above the DAC level) and cleared otherwise, and the next lower bit is set. The stored result is the straight binary code that the search settles on. dac_code_o is 0 while idle.
- R4: data_oe_o is 1 exactly when cs_n_i is 0, rd_n_i is 0 and busy_n_o is 1. data_o carries the stored result when data_oe_o is 1 and is 0 otherwise.
- R5: A rising edge on conv_start_i during a conversion is ignored. The running conversion keeps its 24-cycle length and its result, and no second conversion follows it.
- R6: A conversion starts whatever the levels of cs_n_i and rd_n_i are.
- R7: pwr_down_o rises on the clock edge that samples mode_i low and rd_n_i high while the block is idle. It does not rise while rd_n_i is low. If mode_i goes low during a conversion, the conversion completes first.
- R8: While pwr_down_o is high, start edges are ignored. pwr_down_o falls on the edge that samples mode_i high. A start edge that would be accepted on the next edge is ignored.
- R9: result_invalid_o rises on entry to power-down. It stays 1 through the end of the first conversion after wake and falls at the end of the conversion after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Asynchronous convert-start, rising edge active |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the DAC level |
| cs_n_i | input | 1 | Active-low chip-select |
| rd_n_i | input | 1 | Active-low read |
| mode_i | input | 1 | Power mode, 0 requests sleep |
| dac_code_o | output | 12 | Trial code to the DAC |
| busy_n_o | output | 1 | Low while a conversion runs |
| hold_o | output | 1 | 1 holds the sample, 0 tracks |
| data_o | output | 12 | Result bus value |
| data_oe_o | output | 1 | Result bus drive enable |
| pwr_down_o | output | 1 | Block is in power-down |
| result_invalid_o | output | 1 | Stored result is not valid |

## Verification
A wrong trial mask or phase shows on dac_code_o within one clock of the fault. A wrong keep-or-clear decision shows one trial later and then in the code read back. A wrong sequencer state shows as busy_n_o changing on the wrong edge, as a start that is dropped or doubled, or as a bus enable during conversion, all in the same cycle. A power-sequencer fault shows as pwr_down_o or result_invalid_o disagreeing with the reference model in the cycle it occurs, or as a conversion that starts in the wake clock.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_WAKE  = 2'd2
  } pwr_state_e;

  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_DECIDE = 1'b1
  } sar_phase_e;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] rq_q;
  logic [STAGES-1:0] rq_d;
  logic [STAGES:0]   rq_shift;

  assign rq_shift = {rq_q, 1'b1};
  assign rq_d     = rq_shift[STAGES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq_q <= '0;
    else        rq_q <= rq_d;
  end

  assign rst_sync_n = rq_q[STAGES-1];
endmodule

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic [STAGES:0]   chain_shift;
  logic              last_q;

  assign chain_shift = {chain_q, async_i};
  assign chain_d     = chain_shift[STAGES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             active_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic             active_q, active_d;
  sar_phase_e       phase_q, phase_d;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic [WIDTH-1:0] trial_q, trial_d;
  logic [WIDTH-1:0] result_q;
  logic             decide;
  logic             last_bit;
  logic [WIDTH-1:0] kept;
  logic [WIDTH-1:0] next_mask;

  assign decide    = active_q & (phase_q == PH_DECIDE);
  assign last_bit  = mask_q[0];
  assign kept      = cmp_i ? trial_q : (trial_q & ~mask_q);
  assign next_mask = mask_q >> 1;
  assign done_o    = decide & last_bit;

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    mask_d   = mask_q;
    trial_d  = trial_q;
    if (!active_q) begin
      if (go_i) begin
        active_d = 1'b1;
        phase_d  = PH_SETTLE;
        mask_d   = TOP_BIT;
        trial_d  = TOP_BIT;
      end
    end else if (phase_q == PH_SETTLE) begin
      phase_d = PH_DECIDE;
    end else if (last_bit) begin
      active_d = 1'b0;
      phase_d  = PH_SETTLE;
      mask_d   = '0;
      trial_d  = '0;
    end else begin
      phase_d = PH_SETTLE;
      mask_d  = next_mask;
      trial_d = kept | next_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_SETTLE;
      mask_q   <= '0;
      trial_q  <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      mask_q   <= mask_d;
      trial_q  <= trial_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (done_o) result_q <= kept;
  end

  assign trial_o  = trial_q;
  assign active_o = active_q;
  assign result_o = result_q;
endmodule

// File: rtl/sar_pwr_seq.sv
module sar_pwr_seq
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic rd_n_i,
  input  logic idle_i,
  input  logic done_i,
  output logic asleep_o,
  output logic ready_o,
  output logic invalid_o
);
  pwr_state_e state_q, state_d;
  logic       dummy_q, dummy_d;
  logic       inval_q, inval_d;
  logic       sleep_req;

  assign sleep_req = ~mode_i & rd_n_i;

  always_comb begin
    state_d = state_q;
    dummy_d = dummy_q;
    inval_d = inval_q;
    if (done_i) begin
      inval_d = dummy_q;
      dummy_d = 1'b0;
    end
    unique case (state_q)
      PWR_RUN: begin
        if (idle_i && sleep_req) begin
          state_d = PWR_SLEEP;
          dummy_d = 1'b1;
          inval_d = 1'b1;
        end
      end
      PWR_SLEEP: begin
        if (mode_i) state_d = PWR_WAKE;
      end
      PWR_WAKE: state_d = PWR_RUN;
      default:  state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_RUN;
      dummy_q <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dummy_q <= dummy_d;
      inval_q <= inval_d;
    end
  end

  assign asleep_o  = (state_q == PWR_SLEEP);
  assign ready_o   = (state_q == PWR_RUN) & ~sleep_req;
  assign invalid_o = inval_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_i,
  input  logic             cmp_i,
  input  logic             cs_n_i,
  input  logic             rd_n_i,
  input  logic             mode_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_n_o,
  output logic             hold_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o,
  output logic             pwr_down_o,
  output logic             result_invalid_o
);
  logic             rst_sync_n;
  logic             start_rise;
  logic             go;
  logic             active;
  logic             done;
  logic             ready;
  logic             read_en;
  logic [WIDTH-1:0] trial;
  logic [WIDTH-1:0] result;

  sar_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_edge_sync #(.STAGES(SYNC_STAGES)) u_edge_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (conv_start_i),
    .rise_o  (start_rise)
  );

  assign go = start_rise & ready & ~active;

  sar_search #(.WIDTH(WIDTH)) u_search (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go_i     (go),
    .cmp_i    (cmp_i),
    .trial_o  (trial),
    .active_o (active),
    .done_o   (done),
    .result_o (result)
  );

  sar_pwr_seq u_pwr_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_i    (mode_i),
    .rd_n_i    (rd_n_i),
    .idle_i    (~active),
    .done_i    (done),
    .asleep_o  (pwr_down_o),
    .ready_o   (ready),
    .invalid_o (result_invalid_o)
  );

  assign read_en    = ~cs_n_i & ~rd_n_i & ~active;
  assign busy_n_o   = ~active;
  assign hold_o     = active;
  assign dac_code_o = trial;
  assign data_oe_o  = read_en;
  assign data_o     = read_en ? result : '0;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic [WIDTH-1:0] dac,
  input logic [WIDTH-1:0] data,
  input logic             oe,
  input logic             cs_n,
  input logic             rd_n,
  input logic             pd,
  input logic             invalid
);
  localparam int CONV_LEN = 2 * WIDTH;
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  int low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_len <= 0;
    else if (!busy_n) low_len <= low_len + 1;
    else              low_len <= 0;
  end

  p_conv_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_len == CONV_LEN));

  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> (dac == TOP_BIT));

  p_dac_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> (dac == '0));

  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !oe);

  p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (!cs_n && !rd_n));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe)) |-> $stable(data));

  p_sleep_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> busy_n);

  p_wake_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd) |=> busy_n);

  p_sleep_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> invalid);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .busy_n  (busy_n_o),
  .dac     (dac_code_o),
  .data    (data_o),
  .oe      (data_oe_o),
  .cs_n    (cs_n_i),
  .rd_n    (rd_n_i),
  .pd      (pwr_down_o),
  .invalid (result_invalid_o)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  localparam int W    = 12;
  localparam int CONV = 2 * W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, cs_n, rd_n, mode, cmp;
  int   vin;
  logic [W-1:0] dac, data;
  logic busy_n, hold, oe, pd, inval;

  assign cmp = ({20'd0, dac} <= vin);

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_start_i(start), .cmp_i(cmp),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .mode_i(mode),
    .dac_code_o(dac), .busy_n_o(busy_n), .hold_o(hold),
    .data_o(data), .data_oe_o(oe), .pwr_down_o(pd),
    .result_invalid_o(inval)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, stepped on each clock
  int m_cnt, m_vin, m_res;
  bit m_s1, m_s2, m_s3, m_pd, m_wake, m_dummy, m_inval;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_vin = 0; m_res = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_pd = 0; m_wake = 0; m_dummy = 0; m_inval = 0;
    end else begin
      bit rise;
      rise = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = start;
      if (m_cnt > 0) begin
        if (m_cnt == CONV) begin
          m_cnt = 0; m_res = m_vin; m_inval = m_dummy; m_dummy = 0;
        end else m_cnt++;
      end else if (m_pd) begin
        if (mode) begin m_pd = 0; m_wake = 1; end
      end else if (m_wake) begin
        m_wake = 0;
      end else if (!mode && rd_n) begin
        m_pd = 1; m_dummy = 1; m_inval = 1;
      end else if (rise) begin
        m_cnt = 1; m_vin = vin;
      end
    end
  end

  function automatic int exp_dac(int c, int v);
    int k, hi;
    if (c == 0) return 0;
    k  = W - 1 - (c - 1) / 2;
    hi = (v >> (k + 1)) << (k + 1);
    return hi | (1 << k);
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      bit oe_e;
      oe_e = !cs_n && !rd_n && (m_cnt == 0);
      chk("R2", "busy_n", busy_n, m_cnt == 0);
      chk("R2", "hold", hold, m_cnt != 0);
      chk("R3", "dac_code", dac, exp_dac(m_cnt, m_vin));
      chk("R4", "data_oe", oe, oe_e);
      chk("R4", "data", data, oe_e ? m_res : 0);
      chk("R7", "pwr_down", pd, m_pd);
      chk("R9", "invalid", inval, m_inval);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // start pulse then 32 clocks; reports busy-low count and first low index
  task automatic run_conv(int v, output int lowcnt, output int first_low);
    vin = v; start = 1'b1; lowcnt = 0; first_low = -1;
    for (int i = 0; i < 32; i++) begin
      tick(1);
      if (i == 2) start = 1'b0;
      if (!busy_n) begin
        lowcnt++;
        if (first_low < 0) first_low = i;
      end
    end
  endtask

  task automatic read_chk(string req, int exp);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(req, "read oe", oe, 1);
    chk(req, "read data", data, exp);
    tick(1);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog all-reqs: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lc, fl;
    int vals[8] = '{0, 4095, 2048, 2047, 1365, 2730, 1445, 1};
    rst_n = 1'b0; start = 1'b0; cs_n = 1'b1; rd_n = 1'b1; mode = 1'b1; vin = 0;
    tick(4);
    chk("R1", "busy_n", busy_n, 1); chk("R1", "hold", hold, 0);
    chk("R1", "dac", dac, 0); chk("R1", "oe", oe, 0);
    chk("R1", "pd", pd, 0); chk("R1", "invalid", inval, 0);
    rst_n = 1'b1;
    tick(5);
    read_chk("R1", 0);

    // R2 and R3: timing and search over several codes
    foreach (vals[j]) begin
      run_conv(vals[j], lc, fl);
      chk("R2", "busy low cycles", lc, CONV);
      chk("R2", "first low index", fl, 2);
      read_chk("R3", vals[j]);
    end

    // R6 and R4: start while selected and reading, bus stays off during conversion
    cs_n = 1'b0; rd_n = 1'b0;
    run_conv(3210, lc, fl);
    chk("R6", "busy low cycles", lc, CONV);
    #1 chk("R4", "oe after conversion", oe, 1);
    chk("R6", "data", data, 3210);
    tick(1); cs_n = 1'b1; rd_n = 1'b1;

    // R5: second start during conversion ignored
    vin = 3000; start = 1'b1; lc = 0;
    for (int i = 0; i < 44; i++) begin
      tick(1);
      if (i == 2)  start = 1'b0;
      if (i == 8)  start = 1'b1;
      if (i == 11) start = 1'b0;
      if (!busy_n) lc++;
    end
    chk("R5", "busy low cycles", lc, CONV);
    read_chk("R5", 3000);

    // R7: no sleep while read low, sleep once read released
    mode = 1'b0; rd_n = 1'b0; tick(3);
    chk("R7", "pd with read low", pd, 0);
    rd_n = 1'b1; tick(1);
    chk("R7", "pd entered", pd, 1);
    chk("R9", "invalid on sleep", inval, 1);

    // R8: starts ignored while asleep
    run_conv(500, lc, fl);
    chk("R8", "busy low while asleep", lc, 0);

    // R8: start arriving in the wake clock is ignored
    vin = 777; start = 1'b1; tick(1);
    mode = 1'b1; lc = 0;
    for (int i = 0; i < 32; i++) begin
      tick(1);
      if (i == 4) start = 1'b0;
      if (!busy_n) lc++;
    end
    chk("R8", "pd after wake", pd, 0);
    chk("R8", "busy low after wake start", lc, 0);

    // R9: dummy then valid conversion
    chk("R9", "invalid before dummy", inval, 1);
    run_conv(1000, lc, fl);
    chk("R9", "invalid after dummy", inval, 1);
    run_conv(1234, lc, fl);
    chk("R9", "invalid after second", inval, 0);
    read_chk("R3", 1234);

    // R7: mode low during a conversion lets it complete
    vin = 2500; start = 1'b1; lc = 0;
    for (int i = 0; i < 32; i++) begin
      tick(1);
      if (i == 2) start = 1'b0;
      if (i == 6) mode = 1'b0;
      if (!busy_n) lc++;
    end
    chk("R7", "conversion length under sleep request", lc, CONV);
    chk("R7", "pd after conversion", pd, 1);
    read_chk("R7", 2500);
    mode = 1'b1; tick(3);
    run_conv(100, lc, fl);
    run_conv(200, lc, fl);
    read_chk("R9", 200);

    // mixed stress
    for (int n = 0; n < 20; n++) begin
      cs_n = $urandom_range(0, 1); rd_n = $urandom_range(0, 1);
      run_conv($urandom_range(0, 4095), lc, fl);
      chk("R2", "stress busy low cycles", lc, CONV);
      cs_n = 1'b1; rd_n = 1'b1; tick(1);
    end

    tick(2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule